// File: doc/BRIEF.md
# Modulus Reload Timer Counter

This block is a 16-bit up-counter that wraps to a programmable reload value instead of always wrapping to zero. Each system clock cycle it may advance by one. The advance depends on a count source picked from a 3-bit select field. The sources are six single-cycle tick enables from an external prescaler, or a rising or falling edge of an external clock pin, which is synchronized on the way in. A second pin, the load pin, can force the reload value into the counter on a chosen edge. This lets an outside event restart the period at any time.

Software reaches the block through a small register port with four word addresses. Address 0 is the control and status word, address 1 is the counter, address 2 is the reload latch, and address 3 reads as zero. Writing the counter sets the counter and the latch to the same value in the same cycle. Writing the latch alone only affects the next reload. When the count passes from all-ones, the block sets a sticky overflow flag, and the flag raises an interrupt request when the interrupt level is non-zero. The count value can be placed on either or both of two time-base output buses. An undriven bus reads zero, so several counters can be ORed onto one bus. A global run input holds every counter at rest until the whole group is started. A freeze input, obeyed only when the freeze enable bit is set, stops counting.

Top module: `modulus_reload_counter`

## Requirements
- R1: After reset, the counter, the reload latch and every control field are zero; both buses read zero and the interrupt request is low.
- R2: While run_en is low, the counter changes only through a register write to address 1; ticks and pin edges are ignored.
- R3: Control bits [2:0] select the count source: values 0 to 5 count on tick_in[value], 6 counts on a rising edge and 7 on a falling edge of ext_clk_pin. The pin passes through two synchronizing flops before edge detection. Changing the select field never causes a count on its own.
- R4: When a count occurs at FFFFh, the counter takes the reload latch value and the overflow flag (control bit 11) sets. With the latch at 0000h the counter runs freely through all values. With the latch at FFFFh the flag sets on every count.
- R5: A write to address 2 changes only the reload latch; the counter keeps counting and picks up the new value at the next reload.
- R6: A write to address 1 loads the counter and the latch with the written value in the same cycle. It takes priority over any count in that cycle and never sets the flag, even when 0000h is written over FFFFh.
- R7: Control bits [6:5] set which load_pin edges reload the counter from the latch: bit 5 selects rising, bit 6 selects falling, both select either edge, and neither disables pin reload. The pin is synchronized like ext_clk_pin. A pin reload takes priority over a count in the same cycle and does not set the flag.
- R8: The overflow flag stays set until a write to address 0 with bit 11 at one. If an overflow happens in the same cycle as that clear, the flag stays set.
- R9: irq is high exactly while the flag is set and the interrupt level field (control bits [9:7]) is non-zero.
- R10: With freeze_in high and the freeze enable bit (control bit 10) set, counting and pin reloads stop. Register writes still work, and status bits 12 (synchronized ext_clk_pin) and 13 (synchronized load_pin) keep tracking their pins. With the enable bit clear, freeze_in is ignored.
- R11: Control bit 3 puts the count on bus_a and bit 4 puts it on bus_b; a bus whose bit is clear outputs zero.
- R12: reg_rdata shows the addressed register combinationally: address 0 gives the control fields, the flag and the two pin status bits, with every other bit zero; address 1 gives the counter; address 2 gives the latch; address 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global start; counting and pin reloads are held off while low |
| freeze_in | input | 1 | Freeze request, obeyed when the freeze enable bit is set |
| tick_in | input | 6 | Prescaler tick enables, each one cycle wide |
| ext_clk_pin | input | 1 | External count clock, asynchronous |
| load_pin | input | 1 | External reload trigger, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data |
| bus_a | output | W | Time-base bus A, zero when not driven |
| bus_b | output | W | Time-base bus B, zero when not driven |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check the rules that hold in every cycle. The counter stays at rest while the run input is low or the freeze is honoured. A counter write lands in both the counter and the latch and never raises the flag. A latch write reaches the latch. The flag stays set until it is cleared, and the interrupt request never appears without the flag. The rest can only be shown by the bench scenarios running against its cycle model. This covers the synchronizer latency of both pins, the absence of a count when the select field moves while the pin is steady, and reloads with latch values 0000h and FFFFh. It also covers each load-edge setting, a pin reload winning over a count, and a flag set winning over a clear in the same cycle.

// File: rtl/modulus_reload_counter.sv
module modulus_reload_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         freeze_in,
  input  logic [5:0]   tick_in,
  input  logic         ext_clk_pin,
  input  logic         load_pin,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic [W-1:0] bus_a,
  output logic [W-1:0] bus_b,
  output logic         irq
);
  localparam int SYNC = 3;
  localparam logic [1:0] A_CTL = 2'd0, A_CNT = 2'd1, A_MOD = 2'd2;

  logic [SYNC-1:0] ext_s, ld_s;
  logic [W-1:0]    cnt_q, mod_q;
  logic [2:0]      clk_sel, irq_lvl;
  logic [1:0]      ld_edge;
  logic            drv_a, drv_b, frz_en, flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_s <= '0;
      ld_s  <= '0;
    end else begin
      ext_s <= {ext_s[SYNC-2:0], ext_clk_pin};
      ld_s  <= {ld_s[SYNC-2:0], load_pin};
    end

  wire ext_rise = ext_s[1] & ~ext_s[2];
  wire ext_fall = ~ext_s[1] & ext_s[2];
  wire ld_rise  = ld_s[1] & ~ld_s[2];
  wire ld_fall  = ~ld_s[1] & ld_s[2];

  wire wr_ctl = reg_wr && reg_addr == A_CTL;
  wire wr_cnt = reg_wr && reg_addr == A_CNT;
  wire wr_mod = reg_wr && reg_addr == A_MOD;

  wire       active   = run_en & ~(freeze_in & frz_en);
  wire [7:0] sources  = {ext_fall, ext_rise, tick_in};
  wire       tap_hit  = sources[clk_sel];
  wire       load_hit = (ld_edge[0] & ld_rise) | (ld_edge[1] & ld_fall);
  wire       at_top   = &cnt_q;
  wire       ovf      = active & tap_hit & at_top & ~load_hit & ~wr_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  cnt_q <= '0;
    else if (wr_cnt)             cnt_q <= reg_wdata;
    else if (active && load_hit) cnt_q <= mod_q;
    else if (active && tap_hit)  cnt_q <= at_top ? mod_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                mod_q <= '0;
    else if (wr_cnt || wr_mod) mod_q <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sel <= '0;
      drv_a   <= 1'b0;
      drv_b   <= 1'b0;
      ld_edge <= '0;
      irq_lvl <= '0;
      frz_en  <= 1'b0;
    end else if (wr_ctl) begin
      clk_sel <= reg_wdata[2:0];
      drv_a   <= reg_wdata[3];
      drv_b   <= reg_wdata[4];
      ld_edge <= reg_wdata[6:5];
      irq_lvl <= reg_wdata[9:7];
      frz_en  <= reg_wdata[10];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         flag_q <= 1'b0;
    else if (ovf)                       flag_q <= 1'b1;
    else if (wr_ctl && reg_wdata[11])   flag_q <= 1'b0;

  wire [13:0] ctl_word = {ld_s[1], ext_s[1], flag_q, frz_en, irq_lvl,
                          ld_edge, drv_b, drv_a, clk_sel};

  always_comb
    case (reg_addr)
      A_CTL:   reg_rdata = W'(ctl_word);
      A_CNT:   reg_rdata = cnt_q;
      A_MOD:   reg_rdata = mod_q;
      default: reg_rdata = '0;
    endcase

  assign bus_a = drv_a ? cnt_q : '0;
  assign bus_b = drv_b ? cnt_q : '0;
  assign irq   = flag_q & (|irq_lvl);
endmodule

// File: rtl/modulus_reload_counter_chk.sv
module modulus_reload_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         freeze_in,
  input logic         frz_en,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] mod,
  input logic         flag,
  input logic         irq
);
  wire cnt_wr = reg_wr && reg_addr == 2'd1;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> $stable(cnt));

  assert_latch_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> mod == $past(reg_wdata));

  assert_counter_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(reg_wdata)) && (mod == $past(reg_wdata)));

  assert_no_flag_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !flag) |=> !flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(reg_wr && reg_addr == 2'd0 && reg_wdata[11])) |=> flag);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_in && frz_en && !cnt_wr) |=> $stable(cnt));
endmodule

bind modulus_reload_counter modulus_reload_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .freeze_in(freeze_in),
  .frz_en(frz_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cnt(cnt_q), .mod(mod_q), .flag(flag_q), .irq(irq)
);

// File: tb/test_modulus_reload_counter.sv
`timescale 1ns/1ps
module test_modulus_reload_counter;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, freeze_in = 1'b0;
  logic ext_clk_pin = 1'b0, load_pin = 1'b0, reg_wr = 1'b0;
  logic [5:0]   tick_in = '0;
  logic [1:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata, bus_a, bus_b;
  logic         irq;

  modulus_reload_counter #(.W(W)) i_modulus_reload_counter (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .freeze_in(freeze_in),
    .tick_in(tick_in), .ext_clk_pin(ext_clk_pin), .load_pin(load_pin),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_a(bus_a), .bus_b(bus_b), .irq(irq));

  always #5 clk = ~clk;

  int    checks = 0, fails = 0, rot = 0;
  string cur_req = "R1";

  logic [15:0] m_cnt = '0, m_mod = '0;
  logic [2:0]  m_sel = '0, m_lvl = '0;
  logic [1:0]  m_le = '0;
  logic        m_da = 0, m_db = 0, m_fen = 0, m_flag = 0;
  bit          eh[$] = '{0, 0, 0};
  bit          lh[$] = '{0, 0, 0};

  task automatic chk(string name, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", cur_req, name, got, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_rd();
    case (reg_addr)
      2'd0: return W'({lh[1], eh[1], m_flag, m_fen, m_lvl, m_le, m_db, m_da, m_sel});
      2'd1: return m_cnt;
      2'd2: return m_mod;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_mod = '0; m_sel = '0; m_lvl = '0; m_le = '0;
      m_da = 0; m_db = 0; m_fen = 0; m_flag = 0;
      eh = '{0, 0, 0}; lh = '{0, 0, 0};
    end else begin
      bit e_r, e_f, l_r, l_f, act, hit, lhit, set;
      logic [15:0] n_cnt, n_mod;
      e_r = eh[1] && !eh[2]; e_f = !eh[1] && eh[2];
      l_r = lh[1] && !lh[2]; l_f = !lh[1] && lh[2];
      act = run_en && !(freeze_in && m_fen);
      case (m_sel)
        3'd6: hit = e_r;
        3'd7: hit = e_f;
        default: hit = tick_in[m_sel];
      endcase
      lhit = (m_le[0] && l_r) || (m_le[1] && l_f);
      set = 0; n_cnt = m_cnt; n_mod = m_mod;
      if (reg_wr && reg_addr == 2'd1) begin
        n_cnt = reg_wdata; n_mod = reg_wdata;
      end else begin
        if (act && lhit) n_cnt = m_mod;
        else if (act && hit) begin
          if (m_cnt == 16'hFFFF) begin n_cnt = m_mod; set = 1; end
          else n_cnt = m_cnt + 16'd1;
        end
        if (reg_wr && reg_addr == 2'd2) n_mod = reg_wdata;
      end
      if (set) m_flag = 1;
      else if (reg_wr && reg_addr == 2'd0 && reg_wdata[11]) m_flag = 0;
      if (reg_wr && reg_addr == 2'd0) begin
        m_sel = reg_wdata[2:0]; m_da = reg_wdata[3]; m_db = reg_wdata[4];
        m_le = reg_wdata[6:5]; m_lvl = reg_wdata[9:7]; m_fen = reg_wdata[10];
      end
      m_cnt = n_cnt; m_mod = n_mod;
      eh.push_front(ext_clk_pin); void'(eh.pop_back());
      lh.push_front(load_pin);    void'(lh.pop_back());
    end
    #3;
    chk("reg_rdata", reg_rdata, exp_rd());
    chk("bus_a", bus_a, m_da ? m_cnt : '0);
    chk("bus_b", bus_b, m_db ? m_cnt : '0);
    chk("irq", W'(irq), W'(m_flag && m_lvl != 0));
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      reg_addr = rot[1:0];
      rot++;
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [W-1:0] cw(int sel, int da, int db, int le, int lvl, int fen, int clr);
    logic [W-1:0] v = '0;
    v[2:0] = sel[2:0]; v[3] = da[0]; v[4] = db[0]; v[6:5] = le[1:0];
    v[9:7] = lvl[2:0]; v[10] = fen[0]; v[11] = clr[0];
    return v;
  endfunction

  task automatic toggle_ext(int n, int half);
    for (int i = 0; i < n; i++) begin
      ext_clk_pin = ~ext_clk_pin;
      step(half);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    step(3);
    rst_n = 1'b1;
    step(6);

    cur_req = "R2";
    tick_in = '1;
    wreg(0, cw(0, 1, 0, 0, 1, 0, 0));
    ext_clk_pin = 1; load_pin = 1;
    step(6);
    ext_clk_pin = 0; load_pin = 0;
    step(4);

    cur_req = "R3";
    run_en = 1;
    step(8);
    wreg(0, cw(3, 1, 0, 0, 1, 0, 0));
    for (int i = 0; i < 8; i++) begin
      tick_in = (i % 2) ? 6'b001000 : 6'b000111;
      step(1);
    end
    tick_in = '0;
    wreg(0, cw(6, 1, 0, 0, 1, 0, 0));
    toggle_ext(8, 3);
    wreg(0, cw(7, 1, 0, 0, 1, 0, 0));
    toggle_ext(8, 2);
    ext_clk_pin = 1;
    step(5);
    wreg(0, cw(6, 1, 0, 0, 1, 0, 0));
    step(3);
    wreg(0, cw(7, 1, 0, 0, 1, 0, 0));
    step(3);
    ext_clk_pin = 0;
    step(5);

    cur_req = "R4";
    tick_in = 6'b000001;
    wreg(0, cw(0, 1, 0, 0, 1, 0, 0));
    wreg(1, 16'hFFFA);
    step(10);
    wreg(0, cw(0, 1, 0, 0, 1, 0, 1));
    wreg(1, 16'hFFFC);
    wreg(2, 16'h0000);
    step(8);
    wreg(1, 16'hFFFF);
    step(4);
    wreg(0, cw(0, 1, 0, 0, 1, 0, 1));
    step(3);

    cur_req = "R5";
    wreg(1, 16'hFFF6);
    wreg(2, 16'h0042);
    step(14);

    cur_req = "R6";
    tick_in = '0;
    wreg(1, 16'hFFFF);
    wreg(0, cw(0, 1, 0, 0, 1, 0, 1));
    wreg(1, 16'h0000);
    step(3);
    wreg(1, 16'hFFFF);
    @(negedge clk);
    tick_in = 6'b000001; reg_wr = 1; reg_addr = 2'd1; reg_wdata = 16'h0000;
    step(4);

    cur_req = "R7";
    wreg(1, 16'h0500);
    wreg(2, 16'h0020);
    for (int le = 1; le <= 4; le++) begin
      wreg(0, cw(0, 1, 0, le % 4, 1, 0, 0));
      load_pin = 1;
      step(5);
      load_pin = 0;
      step(5);
    end

    cur_req = "R8";
    wreg(1, 16'hFFFE);
    step(4);
    wreg(0, cw(0, 1, 0, 0, 1, 0, 0));
    step(3);
    wreg(0, cw(0, 1, 0, 0, 1, 0, 1));
    step(3);

    cur_req = "R9";
    wreg(0, cw(0, 1, 0, 0, 0, 0, 1));
    wreg(1, 16'hFFFE);
    step(4);
    wreg(0, cw(0, 1, 0, 0, 5, 0, 0));
    step(3);

    cur_req = "R10";
    wreg(0, cw(0, 1, 0, 3, 1, 1, 1));
    freeze_in = 1;
    step(3);
    ext_clk_pin = 1; load_pin = 1;
    step(6);
    wreg(2, 16'h0077);
    ext_clk_pin = 0; load_pin = 0;
    step(4);
    freeze_in = 0;
    step(4);
    freeze_in = 1;
    wreg(0, cw(0, 1, 0, 0, 1, 0, 0));
    step(6);
    freeze_in = 0;

    cur_req = "R11";
    for (int d = 0; d < 4; d++) begin
      wreg(0, cw(0, d % 2, d / 2, 0, 1, 0, 0));
      step(4);
    end

    cur_req = "R12";
    step(12);
    run_en = 0;
    step(2);
    finish_run();
  end
endmodule